// File: doc/BRIEF.md
# Port and Memory Address Former for an 8-bit Processor

This block produces the 16-bit address and the bus strobes for the port input and port output operations of a small 8-bit processor. It also handles one memory load that takes its address from the same register pair. On a start pulse it samples an operation code and the current register values. It drives the address one cycle before any strobe falls. It then holds the request and direction strobes low for a parameterised number of cycles. After that it keeps the address for one more cycle once the strobes have risen. A busy flag covers the whole sequence.

Both address bytes are always driven, with nothing masked. In the register-indirect port forms the high byte is B and the low byte is C. In the immediate-port forms the block first fills a hidden 16-bit holding pair with the accumulator as the high byte and the immediate operand as the low byte, and then drives the address from that pair. The low byte picks one of 256 ports. Many systems also decode the high byte, either as an extra parameter or as a row select. A memory load through BC gives exactly the same address as a port read through C. The only difference is that the memory request strobe falls instead of the port request strobe.

Top module: `ioaddr_former`

## Requirements
- R1: During and directly after reset, addr is 0x0000, io_req_n, mem_req_n, rd_n and wr_n are 1, and busy is 0.
- R2: The register-indirect port forms use op code 0 for input and op code 1 for output. For these, addr equals {B, C}, with B on bits 15..8 and C on bits 7..0, as sampled in the accepting cycle.
- R3: The immediate port forms use op code 2 for input and op code 3 for output. For these, addr equals {A, immediate}, with A on bits 15..8, taken from the hidden pair loaded in the accepting cycle.
- R4: The memory load through BC uses op code 4. It drives the same {B, C} address as op code 0, pulls mem_req_n low and leaves io_req_n high.
- R5: The address is valid in the first cycle after acceptance, and all strobes are still high in that cycle. The request strobe is low from the second cycle after acceptance for ACT_CYC cycles.
- R6: addr does not change while a strobe is low, nor in the cycle after the strobes rise.
- R7: io_req_n and mem_req_n are never low in the same cycle.
- R8: rd_n is low exactly while the request is low for op codes 0, 2 and 4. wr_n is low exactly while the request is low for op codes 1 and 3. Both are never low together.
- R9: busy is 1 from the cycle after acceptance through the one cycle after the strobes rise. A start seen while busy is 1 has no effect.
- R10: A start with op codes 5, 6 or 7 is ignored. busy stays 0, no strobe falls and addr keeps its value.
- R11: Every bit of both address bytes passes unmodified, including the all-ones and all-zero bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse, sampled when not busy |
| op | input | 3 | Operation code (0..4 valid) |
| reg_a | input | DW | Accumulator value |
| reg_b | input | DW | B register value |
| reg_c | input | DW | C register value |
| imm | input | DW | Immediate port operand |
| addr | output | 2*DW | Address bus |
| io_req_n | output | 1 | Port request strobe, active low |
| mem_req_n | output | 1 | Memory request strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| busy | output | 1 | Sequence in progress |

## Verification
Two events can land in the same cycle: a new start pulse and the closing hold cycle of the access before it. In that cycle busy is still set, so the start must be dropped. The bench provokes this by holding start high for many consecutive cycles while changing the op code and register values every cycle. A behavioural phase counter in the bench then decides, cycle by cycle, which starts are taken. It compares the address, every strobe and busy against that counter, so an access that begins one cycle early, or an address overwritten during a hold, is reported.

// File: rtl/ioaddr_pkg.sv
package ioaddr_pkg;

  typedef enum logic [2:0] {
    OP_IN_REG  = 3'd0,
    OP_OUT_REG = 3'd1,
    OP_IN_IMM  = 3'd2,
    OP_OUT_IMM = 3'd3,
    OP_LD_BC   = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ACTIVE,
    PH_HOLD
  } phase_e;

  typedef struct packed {
    logic is_mem;
    logic is_write;
    logic is_imm;
  } acc_t;

  function automatic logic op_valid(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

  function automatic acc_t op_decode(input logic [2:0] code);
    acc_t d;
    d.is_mem   = (code == OP_LD_BC);
    d.is_write = (code == OP_OUT_REG) || (code == OP_OUT_IMM);
    d.is_imm   = (code == OP_IN_IMM) || (code == OP_OUT_IMM);
    return d;
  endfunction

endpackage

// File: rtl/ioaddr_select.sv
module ioaddr_select #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            use_imm,
  input  logic [DW-1:0]   reg_a,
  input  logic [DW-1:0]   reg_b,
  input  logic [DW-1:0]   reg_c,
  input  logic [DW-1:0]   imm,
  output logic [2*DW-1:0] addr
);
  localparam int AW = 2 * DW;

  logic [AW-1:0] hold_pair_q;
  logic [AW-1:0] bc_q;
  logic          sel_imm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_pair_q <= '0;
      bc_q        <= '0;
      sel_imm_q   <= 1'b0;
    end else if (load) begin
      sel_imm_q <= use_imm;
      if (use_imm) hold_pair_q <= {reg_a, imm};
      else         bc_q        <= {reg_b, reg_c};
    end
  end

  assign addr = sel_imm_q ? hold_pair_q : bc_q;

endmodule

// File: rtl/ioaddr_seq.sv
module ioaddr_seq
  import ioaddr_pkg::*;
#(
  parameter int ACT_CYC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [2:0] op,
  output logic       accept,
  output logic       use_imm,
  output phase_e     phase_d,
  output logic       mem_d,
  output logic       write_d
);
  localparam int CW = (ACT_CYC > 1) ? $clog2(ACT_CYC) : 1;

  phase_e        phase_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          mem_q, write_q;
  acc_t          dec;

  assign dec     = op_decode(op);
  assign use_imm = dec.is_imm;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    mem_d   = mem_q;
    write_d = write_q;
    accept  = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start && op_valid(op)) begin
          accept  = 1'b1;
          mem_d   = dec.is_mem;
          write_d = dec.is_write;
          phase_d = PH_SETUP;
        end
      end
      PH_SETUP: begin
        phase_d = PH_ACTIVE;
        cnt_d   = CW'(ACT_CYC - 1);
      end
      PH_ACTIVE: begin
        if (cnt_q == '0) phase_d = PH_HOLD;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      mem_q   <= 1'b0;
      write_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      mem_q   <= mem_d;
      write_q <= write_d;
    end
  end

endmodule

// File: rtl/ioaddr_strobe.sv
module ioaddr_strobe
  import ioaddr_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_e phase_d,
  input  logic   mem_d,
  input  logic   write_d,
  output logic   io_req_n,
  output logic   mem_req_n,
  output logic   rd_n,
  output logic   wr_n,
  output logic   busy
);
  logic act;
  assign act = (phase_d == PH_ACTIVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      io_req_n  <= 1'b1;
      mem_req_n <= 1'b1;
      rd_n      <= 1'b1;
      wr_n      <= 1'b1;
      busy      <= 1'b0;
    end else begin
      io_req_n  <= !(act && !mem_d);
      mem_req_n <= !(act && mem_d);
      rd_n      <= !(act && !write_d);
      wr_n      <= !(act && write_d);
      busy      <= (phase_d != PH_IDLE);
    end
  end

endmodule

// File: rtl/ioaddr_former.sv
module ioaddr_former
  import ioaddr_pkg::*;
#(
  parameter int DW      = 8,
  parameter int ACT_CYC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [2:0]      op,
  input  logic [DW-1:0]   reg_a,
  input  logic [DW-1:0]   reg_b,
  input  logic [DW-1:0]   reg_c,
  input  logic [DW-1:0]   imm,
  output logic [2*DW-1:0] addr,
  output logic            io_req_n,
  output logic            mem_req_n,
  output logic            rd_n,
  output logic            wr_n,
  output logic            busy
);
  logic   accept, use_imm, mem_d, write_d;
  phase_e phase_d;

  ioaddr_seq #(.ACT_CYC(ACT_CYC)) u_seq (
    .clk(clk), .rst(rst), .start(start), .op(op),
    .accept(accept), .use_imm(use_imm), .phase_d(phase_d),
    .mem_d(mem_d), .write_d(write_d)
  );

  ioaddr_select #(.DW(DW)) u_sel (
    .clk(clk), .rst(rst), .load(accept), .use_imm(use_imm),
    .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c), .imm(imm),
    .addr(addr)
  );

  ioaddr_strobe u_stb (
    .clk(clk), .rst(rst), .phase_d(phase_d), .mem_d(mem_d),
    .write_d(write_d), .io_req_n(io_req_n), .mem_req_n(mem_req_n),
    .rd_n(rd_n), .wr_n(wr_n), .busy(busy)
  );

endmodule

// File: rtl/ioaddr_former_chk.sv
module ioaddr_former_chk #(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic [2:0]      op,
  input logic [2*DW-1:0] addr,
  input logic            io_req_n,
  input logic            mem_req_n,
  input logic            rd_n,
  input logic            wr_n,
  input logic            busy
);
  logic req;
  assign req = !io_req_n || !mem_req_n;

  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!io_req_n && !mem_req_n)); // R7

  AST_ADDR_SETUP: assert property (@(posedge clk) disable iff (rst)
    ($fell(io_req_n) || $fell(mem_req_n)) |-> $stable(addr)); // R5

  AST_ADDR_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    req |-> $stable(addr)); // R6

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($rose(io_req_n) || $rose(mem_req_n)) |=> $stable(addr)); // R6

  AST_DIR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n)); // R8

  AST_DIR_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> req); // R8

  AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (rst)
    req |-> busy); // R9

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && op <= 3'd4) |=> busy); // R9

  AST_BAD_OP_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && op > 3'd4) |=> (!busy && $stable(addr))); // R10

endmodule

bind ioaddr_former ioaddr_former_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .op(op), .addr(addr),
  .io_req_n(io_req_n), .mem_req_n(mem_req_n), .rd_n(rd_n),
  .wr_n(wr_n), .busy(busy)
);

// File: tb/ioaddr_former_test.sv
module ioaddr_former_test;
  localparam int DW  = 8;
  localparam int ACT = 2;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [2:0] op = 3'd0;
  logic [7:0] ra = 8'h00, rb = 8'h00, rc = 8'h00, rim = 8'h00;
  logic [15:0] addr;
  logic io_req_n, mem_req_n, rd_n, wr_n, busy;

  int checks = 0, errors = 0;
  int ph = 0, eop = 0;
  logic [15:0] eaddr = 16'h0000, prev_addr = 16'h0000;
  bit finished = 0;

  always #2 clk = ~clk;

  ioaddr_former #(.DW(DW), .ACT_CYC(ACT)) uut (
    .clk(clk), .rst(rst), .start(start), .op(op), .reg_a(ra), .reg_b(rb),
    .reg_c(rc), .imm(rim), .addr(addr), .io_req_n(io_req_n),
    .mem_req_n(mem_req_n), .rd_n(rd_n), .wr_n(wr_n), .busy(busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference: phase counter
  always @(posedge clk) begin
    if (rst) begin
      ph = 0; eaddr = 16'h0000; eop = 0;
    end else if (ph == 0) begin
      if (start && op <= 3'd4) begin
        ph = 1;
        eop = int'(op);
        eaddr = (op == 3'd2 || op == 3'd3) ? {ra, rim} : {rb, rc};
      end
    end else if (ph == ACT + 2) ph = 0;
    else ph = ph + 1;
  end

  always @(negedge clk) begin
    if (!rst) begin
      bit req;
      req = (ph >= 2) && (ph <= ACT + 1);
      chk((eop == 2 || eop == 3) ? "R3 addr" : (eop == 4) ? "R4 addr" : "R2 addr",
          32'(addr), 32'(eaddr));
      chk("R9 busy", 32'(busy), 32'(ph != 0));
      chk("R5 io_req_n", 32'(io_req_n), 32'(!(req && eop != 4)));
      chk("R4 mem_req_n", 32'(mem_req_n), 32'(!(req && eop == 4)));
      chk("R8 rd_n", 32'(rd_n), 32'(!(req && (eop == 0 || eop == 2 || eop == 4))));
      chk("R8 wr_n", 32'(wr_n), 32'(!(req && (eop == 1 || eop == 3))));
      chk("R7 both requests", 32'(!io_req_n && !mem_req_n), 32'd0);
      if (ph >= 2) chk("R6 addr held", 32'(addr), 32'(prev_addr));
    end
    prev_addr = addr;
  end

  task automatic issue(input logic [2:0] o, input logic [7:0] a, b, c, i);
    @(negedge clk);
    op = o; ra = a; rb = b; rc = c; rim = i; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ra = 8'h5A; rb = 8'hA5; rc = 8'h3C; rim = 8'hC3;
    while (busy) @(negedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset values
    chk("R1 addr", 32'(addr), 32'h0);
    chk("R1 strobes", 32'({io_req_n, mem_req_n, rd_n, wr_n}), 32'hF);
    chk("R1 busy", 32'(busy), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", 32'({busy, io_req_n, mem_req_n, rd_n, wr_n}), 32'h0F);

    issue(3'd0, 8'h11, 8'hFB, 8'hFE, 8'h22);   // R2 read
    chk("R2 read addr", 32'(addr), 32'hFBFE);
    issue(3'd1, 8'h11, 8'h12, 8'h34, 8'h22);   // R2 write
    chk("R2 write addr", 32'(addr), 32'h1234);
    issue(3'd2, 8'hFB, 8'h01, 8'h02, 8'hFE);   // R3 read
    chk("R3 read addr", 32'(addr), 32'hFBFE);
    issue(3'd3, 8'h34, 8'h01, 8'h02, 8'h34);   // R3 write
    chk("R3 write addr", 32'(addr), 32'h3434);
    issue(3'd4, 8'h00, 8'hFB, 8'hFE, 8'h77);   // R4 memory load
    chk("R4 same as port read", 32'(addr), 32'hFBFE);
    issue(3'd2, 8'hFF, 8'h01, 8'h02, 8'h00);   // R11
    chk("R11 ones/zeros", 32'(addr), 32'hFF00);
    issue(3'd0, 8'h00, 8'h00, 8'hFF, 8'h00);   // R11
    chk("R11 zeros/ones", 32'(addr), 32'h00FF);

    // R10: illegal codes ignored
    for (int k = 5; k < 8; k++) begin
      @(negedge clk);
      op = 3'(k); rb = 8'h99; rc = 8'h88; ra = 8'h77; rim = 8'h66; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R10 busy", 32'(busy), 32'h0);
      chk("R10 addr", 32'(addr), 32'h00FF);
      @(negedge clk);
      chk("R10 strobes", 32'({io_req_n, mem_req_n, rd_n, wr_n}), 32'hF);
    end

    // R9: start held high, values change each cycle
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      start = 1'b1;
      op = 3'(k % 5);
      ra = 8'(k * 7); rb = 8'(k * 13 + 1); rc = 8'(k * 3 + 5); rim = 8'(k * 11);
    end
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);

    // mixed traffic
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      start = ($urandom % 3) != 0;
      op = 3'($urandom % 8);
      ra = 8'($urandom); rb = 8'($urandom); rc = 8'($urandom); rim = 8'($urandom);
    end
    @(negedge clk);
    start = 1'b0;
    repeat (ACT + 4) @(negedge clk);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

endmodule